// File: doc/BRIEF.md
# Receive Message Buffer with Overrun Policy

This block keeps one received serial-bus message, up to eight payload bytes plus a byte count, until software reads it and releases the slot. A receive engine upstream presents each complete, checked message as a one-cycle strobe together with its length and data. The block stores the message, raises a full indication and holds the payload steady on its outputs until a release strobe frees the slot.

If a further valid message arrives while the slot is still occupied, one message is lost and a sticky overrun flag is raised. A configuration input chooses which message is lost. When it is low, the newcomer replaces the stored message, so software always finds the latest one. When it is high, the slot is locked: the newcomer is dropped and the older message stays. A release in the same cycle as an arrival frees the slot for that arrival, so no message is lost. Lengths above the byte capacity are saturated, and bytes beyond the stored length read as zero.

Top module: `rxb_msg_buffer`

## Requirements
- R1: After reset, buf_full and ovr_flag are 0, buf_len is 0 and buf_data is all zeros.
- R2: A msg_valid strobe while the slot is empty stores the message. One cycle later buf_full is 1 and buf_len and buf_data show the message.
- R3: A release strobe (rel=1) without msg_valid clears buf_full on the next cycle. A release while the slot is empty changes neither buf_full nor ovr_flag.
- R4: A msg_valid strobe while buf_full is 1 and rel is 0 is an overrun. It sets ovr_flag on the next cycle, whatever the value of lock_mode.
- R5: On an overrun with lock_mode=0, the incoming message replaces the stored one, and buf_full stays 1.
- R6: On an overrun with lock_mode=1, the incoming message is dropped: buf_len and buf_data keep their values and buf_full stays 1.
- R7: When rel and msg_valid are both 1 in one cycle, the incoming message is stored, buf_full stays 1 and no overrun is flagged.
- R8: ovr_flag stays 1 until a cycle with ovr_clr=1. A new overrun in the same cycle as ovr_clr leaves the flag set.
- R9: A msg_len above MAX_BYTES (8) is stored as MAX_BYTES. Byte k of buf_data (bits 8k+7:8k) reads 0 for every k at or above the stored length.
- R10: A release leaves buf_len and buf_data unchanged. They change only when a message is stored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| msg_valid | input | 1 | One-cycle strobe: a complete, checked message is present |
| msg_len | input | 4 | Byte count of the incoming message (saturated to 8) |
| msg_data | input | 64 | Incoming payload; byte k is bits 8k+7:8k |
| rel | input | 1 | Software has read the slot and releases it |
| lock_mode | input | 1 | 0: an overrun keeps the newest message; 1: it keeps the oldest |
| ovr_clr | input | 1 | Write-one-to-clear for the overrun flag |
| buf_data | output | 64 | Stored payload, with bytes beyond buf_len zero |
| buf_len | output | 4 | Stored byte count |
| buf_full | output | 1 | Slot holds an unreleased message |
| ovr_flag | output | 1 | Sticky overrun indication |

## Verification
The bench builds the block with its defaults: MAX_BYTES=8 and BYTE_W=8, which gives a 4-bit length field. Lengths 9 to 15 can therefore be driven, so the saturation rule is exercised, and every masking boundary from zero to eight bytes is reachable. With a single slot, back-to-back arrivals, same-cycle release and arrival, and clear-versus-set collisions on the flag all occur within a few cycles under random stimulus.

// File: rtl/rxb_pkg.sv
`timescale 1ns/1ps
package rxb_pkg;

  typedef enum logic {
    RXB_KEEP_NEWEST = 1'b0,
    RXB_KEEP_OLDEST = 1'b1
  } rxb_policy_e;

  typedef struct packed {
    logic store;
    logic overrun;
    logic full_nxt;
  } rxb_dec_t;

endpackage

// File: rtl/rxb_ctrl.sv
`timescale 1ns/1ps
module rxb_ctrl
  import rxb_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic msg_valid,
  input  logic rel,
  input  logic lock_mode,
  output logic full,
  output logic store,
  output logic overrun
);

  rxb_dec_t dec;

  function automatic rxb_dec_t decide(input logic v, input logic r,
                                      input rxb_policy_e pol, input logic f);
    rxb_dec_t d;
    d.overrun  = v & f & ~r;
    d.store    = v & (~f | r | (pol == RXB_KEEP_NEWEST));
    d.full_nxt = d.store | (f & ~r);
    return d;
  endfunction

  always_comb dec = decide(msg_valid, rel, rxb_policy_e'(lock_mode), full);

  always_ff @(posedge clk) begin
    if (!rst_n) full <= 1'b0;
    else        full <= dec.full_nxt;
  end

  assign store   = dec.store;
  assign overrun = dec.overrun;

endmodule

// File: rtl/rxb_store.sv
`timescale 1ns/1ps
module rxb_store #(
  parameter int MAX_BYTES = 8,
  parameter int BYTE_W    = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        store,
  input  logic [LEN_W-1:0]            in_len,
  input  logic [MAX_BYTES*BYTE_W-1:0] in_data,
  output logic [LEN_W-1:0]            len_q,
  output logic [MAX_BYTES*BYTE_W-1:0] data_q
);

  localparam logic [LEN_W-1:0] LEN_CAP = LEN_W'(MAX_BYTES);

  function automatic logic [LEN_W-1:0] clamp_len(input logic [LEN_W-1:0] l);
    return (l > LEN_CAP) ? LEN_CAP : l;
  endfunction

  logic [LEN_W-1:0] len_c;
  assign len_c = clamp_len(in_len);

  always_ff @(posedge clk) begin
    if (!rst_n)     len_q <= '0;
    else if (store) len_q <= len_c;
  end

  for (genvar b = 0; b < MAX_BYTES; b++) begin : g_byte
    logic keep;
    assign keep = (LEN_W'(b) < len_c);
    always_ff @(posedge clk) begin
      if (!rst_n)
        data_q[b*BYTE_W +: BYTE_W] <= '0;
      else if (store)
        data_q[b*BYTE_W +: BYTE_W] <= keep ? in_data[b*BYTE_W +: BYTE_W] : '0;
    end
  end

endmodule

// File: rtl/rxb_ovr.sv
`timescale 1ns/1ps
module rxb_ovr (
  input  logic clk,
  input  logic rst_n,
  input  logic set_evt,
  input  logic clr_req,
  output logic flag
);

  always_ff @(posedge clk) begin
    if (!rst_n) flag <= 1'b0;
    else        flag <= set_evt | (flag & ~clr_req);
  end

endmodule

// File: rtl/rxb_msg_buffer.sv
`timescale 1ns/1ps
module rxb_msg_buffer #(
  parameter int MAX_BYTES = 8,
  parameter int BYTE_W    = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        msg_valid,
  input  logic [LEN_W-1:0]            msg_len,
  input  logic [MAX_BYTES*BYTE_W-1:0] msg_data,
  input  logic                        rel,
  input  logic                        lock_mode,
  input  logic                        ovr_clr,
  output logic [MAX_BYTES*BYTE_W-1:0] buf_data,
  output logic [LEN_W-1:0]            buf_len,
  output logic                        buf_full,
  output logic                        ovr_flag
);

  logic evt_store;
  logic evt_overrun;

  rxb_ctrl u_ctrl (
    .clk       (clk),
    .rst_n     (rst_n),
    .msg_valid (msg_valid),
    .rel       (rel),
    .lock_mode (lock_mode),
    .full      (buf_full),
    .store     (evt_store),
    .overrun   (evt_overrun)
  );

  rxb_store #(.MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W), .LEN_W(LEN_W)) u_store (
    .clk     (clk),
    .rst_n   (rst_n),
    .store   (evt_store),
    .in_len  (msg_len),
    .in_data (msg_data),
    .len_q   (buf_len),
    .data_q  (buf_data)
  );

  rxb_ovr u_ovr (
    .clk     (clk),
    .rst_n   (rst_n),
    .set_evt (evt_overrun),
    .clr_req (ovr_clr),
    .flag    (ovr_flag)
  );

endmodule

// File: rtl/rxb_msg_buffer_chk.sv
`timescale 1ns/1ps
module rxb_msg_buffer_chk #(
  parameter int MAX_BYTES = 8,
  parameter int BYTE_W    = 8,
  parameter int LEN_W     = $clog2(MAX_BYTES + 1)
) (
  input logic                        clk,
  input logic                        rst_n,
  input logic                        msg_valid,
  input logic                        rel,
  input logic                        lock_mode,
  input logic                        ovr_clr,
  input logic [MAX_BYTES*BYTE_W-1:0] buf_data,
  input logic [LEN_W-1:0]            buf_len,
  input logic                        buf_full,
  input logic                        ovr_flag,
  input logic                        evt_store,
  input logic                        evt_overrun
);

  a_r2_store_sets_full: assert property (@(posedge clk) disable iff (!rst_n)
    evt_store |=> buf_full);

  a_r3_release_clears: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && !msg_valid) |=> !buf_full);

  a_r4_overrun_flags: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |=> ovr_flag);

  a_r4_overrun_needs_full: assert property (@(posedge clk) disable iff (!rst_n)
    evt_overrun |-> (buf_full && msg_valid && !rel));

  a_r6_locked_keeps: assert property (@(posedge clk) disable iff (!rst_n)
    (msg_valid && buf_full && !rel && lock_mode) |=> ($stable(buf_data) && $stable(buf_len)));

  a_r7_release_no_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    (rel && msg_valid && !ovr_flag) |=> (!ovr_flag && buf_full));

  a_r8_sticky: assert property (@(posedge clk) disable iff (!rst_n)
    (ovr_flag && !ovr_clr) |=> ovr_flag);

  a_r10_payload_hold: assert property (@(posedge clk) disable iff (!rst_n)
    !evt_store |=> ($stable(buf_data) && $stable(buf_len)));

  always_ff @(posedge clk) begin
    if (rst_n) a_r9_len_bound: assert (buf_len <= LEN_W'(MAX_BYTES));
  end

endmodule

bind rxb_msg_buffer rxb_msg_buffer_chk #(
  .MAX_BYTES(MAX_BYTES), .BYTE_W(BYTE_W), .LEN_W(LEN_W)
) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .msg_valid   (msg_valid),
  .rel         (rel),
  .lock_mode   (lock_mode),
  .ovr_clr     (ovr_clr),
  .buf_data    (buf_data),
  .buf_len     (buf_len),
  .buf_full    (buf_full),
  .ovr_flag    (ovr_flag),
  .evt_store   (evt_store),
  .evt_overrun (evt_overrun)
);

// File: tb/sim_rxb_msg_buffer.sv
`timescale 1ns/1ps
module sim_rxb_msg_buffer;

  localparam int MAXB = 8;
  localparam int BW   = 8;
  localparam int LW   = 4;
  localparam int DW   = MAXB * BW;

  logic          clk = 1'b0;
  logic          rst_n;
  logic          msg_valid, rel, lock_mode, ovr_clr;
  logic [LW-1:0] msg_len;
  logic [DW-1:0] msg_data;
  logic [DW-1:0] buf_data;
  logic [LW-1:0] buf_len;
  logic          buf_full, ovr_flag;

  always #4 clk = ~clk;

  rxb_msg_buffer u0 (
    .clk(clk), .rst_n(rst_n), .msg_valid(msg_valid), .msg_len(msg_len),
    .msg_data(msg_data), .rel(rel), .lock_mode(lock_mode), .ovr_clr(ovr_clr),
    .buf_data(buf_data), .buf_len(buf_len), .buf_full(buf_full), .ovr_flag(ovr_flag)
  );

  int n_chk = 0;
  int n_bad = 0;
  bit done  = 0;

  logic          m_full, m_ovr;
  logic [LW-1:0] m_len;
  logic [DW-1:0] m_data;

  function automatic logic [LW-1:0] exp_len(input logic [LW-1:0] l);
    int n = int'(l);
    if (n > MAXB) n = MAXB;
    return LW'(n);
  endfunction

  function automatic logic [DW-1:0] exp_data(input logic [DW-1:0] d, input logic [LW-1:0] l);
    logic [2*DW-1:0] m;
    m = ({{DW{1'b0}}, {DW{1'b0}}} + 1) << (int'(exp_len(l)) * BW);
    m = m - 1;
    return d & m[DW-1:0];
  endfunction

  task automatic chk(input string tag, input string what, input logic [DW-1:0] act, input logic [DW-1:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s %s: actual %h expected %h", tag, what, act, exp);
    end
  endtask

  task automatic compare_all(input string tag);
    chk(tag, "buf_full", DW'(buf_full), DW'(m_full));
    chk(tag, "ovr_flag", DW'(ovr_flag), DW'(m_ovr));
    chk(tag, "buf_len",  DW'(buf_len),  DW'(m_len));
    chk(tag, "buf_data", buf_data, m_data);
  endtask

  // called at a falling edge; applies inputs for one rising edge, then compares
  task automatic step(input logic v, input logic [LW-1:0] l, input logic [DW-1:0] d,
                      input logic r, input logic lk, input logic c, input string tag);
    logic ov, st;
    msg_valid = v; msg_len = l; msg_data = d; rel = r; lock_mode = lk; ovr_clr = c;
    @(posedge clk);
    ov = v && m_full && !r;
    st = v && (!m_full || r || !lk);
    if (st) begin m_len = exp_len(l); m_data = exp_data(d, l); end
    m_full = st ? 1'b1 : (r ? 1'b0 : m_full);
    m_ovr  = ov ? 1'b1 : (c ? 1'b0 : m_ovr);
    @(negedge clk);
    msg_valid = 0; rel = 0; ovr_clr = 0;
    compare_all(tag);
  endtask

  task automatic idle(input string tag);
    step(0, '0, '0, 0, lock_mode, 0, tag);
  endtask

  initial begin
    #(200000 * 8);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    void'($urandom(32'h5EED_1234));
    rst_n = 0; msg_valid = 0; rel = 0; lock_mode = 0; ovr_clr = 0;
    msg_len = '0; msg_data = '0;
    m_full = 0; m_ovr = 0; m_len = '0; m_data = '0;
    repeat (3) @(posedge clk);
    @(negedge clk);
    rst_n = 1;
    compare_all("R1");

    // R3: release while empty does nothing
    step(0, '0, '0, 1, 0, 0, "R3");
    // R2: store into empty slot
    step(1, 4'd8, 64'h8877_6655_4433_2211, 0, 0, 0, "R2");
    // R10: release keeps payload
    step(0, '0, '0, 1, 0, 0, "R10");
    chk("R10", "buf_data kept", buf_data, 64'h8877_6655_4433_2211);
    // R3: full cleared
    chk("R3", "buf_full after release", DW'(buf_full), '0);
    // R9: short length masks upper bytes; long length saturates
    step(1, 4'd3, 64'hFFFF_FFFF_FFAA_BBCC, 0, 0, 0, "R9");
    chk("R9", "masked data", buf_data, 64'h0000_0000_00AA_BBCC);
    step(0, '0, '0, 1, 0, 0, "R9");
    step(1, 4'd13, 64'h0102_0304_0506_0708, 0, 0, 0, "R9");
    chk("R9", "saturated len", DW'(buf_len), DW'(8));
    // R4 + R5: unlocked overrun overwrites
    step(1, 4'd2, 64'h0000_0000_0000_BEEF, 0, 0, 0, "R5");
    chk("R4", "ovr_flag set", DW'(ovr_flag), 1);
    chk("R5", "newest kept", buf_data, 64'h0000_0000_0000_BEEF);
    // R8: sticky, then clear
    idle("R8");
    chk("R8", "still set", DW'(ovr_flag), 1);
    step(0, '0, '0, 0, 0, 1, "R8");
    chk("R8", "cleared", DW'(ovr_flag), 0);
    // R6: locked overrun drops incoming
    step(1, 4'd1, 64'h55, 0, 1, 0, "R6");
    chk("R6", "oldest kept", buf_data, 64'h0000_0000_0000_BEEF);
    chk("R4", "ovr_flag locked", DW'(ovr_flag), 1);
    // R8: set wins over clear
    step(1, 4'd1, 64'h66, 0, 1, 1, "R8");
    chk("R8", "set beats clear", DW'(ovr_flag), 1);
    step(0, '0, '0, 0, 1, 1, "R8");
    // R7: release and arrival together, locked mode
    step(1, 4'd4, 64'h0000_0000_CAFE_F00D, 1, 1, 0, "R7");
    chk("R7", "no overrun", DW'(ovr_flag), 0);
    chk("R7", "stored", buf_data, 64'h0000_0000_CAFE_F00D);
    // zero-length message
    step(0, '0, '0, 1, 0, 0, "R9");
    step(1, 4'd0, 64'hFFFF_FFFF_FFFF_FFFF, 0, 0, 0, "R9");
    chk("R9", "zero length data", buf_data, '0);

    for (int i = 0; i < 3000; i++) begin
      logic v, r, lk, c;
      v  = ($urandom % 2) == 0;
      r  = ($urandom % 10) < 3;
      lk = ($urandom % 2) == 1;
      c  = ($urandom % 10) == 0;
      step(v, LW'($urandom % 16), {$urandom, $urandom}, r, lk, c, "R5/R6 random");
    end

    done = 1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end

endmodule